// File: doc/BRIEF.md
# Pointer Bounds Register Check Unit

This block keeps a small file of four 128-bit bounds registers and runs pointer bounds checks against them. Each register pairs a lower bound with an upper bound. One operation is accepted per clock: build bounds from a base and an offset, copy one register into another, fill a register from a 128-bit data input, spill a register to a 128-bit data output, or check a 64-bit address against one side of a chosen register.

The upper bound is kept inverted, so an all-zero register image describes the full address space. Every register resets to that image. A check against an all-zero image always passes. Two upper-bound checks exist. The direct check compares against the stored bits as they are. The inverting check compares against their one's complement, and it is the one that matches bounds built by the make operation.

A failed check produces a one-cycle violation pulse. It also captures the address, both stored bound fields and the side that was crossed, and holds that record until software-side logic acknowledges it.

Top module: `bnd_check_unit`

## Requirements
- R1: After reset, all four registers hold the all-zero image. Spilling any of them returns 128'h0.
- R2: In a register image, bits 63:0 are the lower bound and bits 127:64 are the stored upper field.
- R3: Op code 1 (make) writes lower = base_addr and stored upper = ~(base_addr + offset), modulo 2^64, into the register dst_sel. This makes the region inclusive of both ends.
- R4: Op code 2 copies register src_sel into dst_sel. Op code 3 writes mem_wdata into dst_sel. Op code 4 drives register src_sel onto mem_rdata with mem_rvalid high for exactly the following cycle.
- R5: Op code 5 (lower check) fails when base_addr < lower bound, compared unsigned. An address equal to the bound passes.
- R6: Op code 6 (direct upper check) fails when base_addr > stored upper field, compared unsigned. Equality passes.
- R7: Op code 7 (inverting upper check) fails when base_addr > ~stored upper field. Equality passes.
- R8: A check against a register whose whole image is zero never fails, for any of op codes 5, 6 and 7.
- R9: viol_pulse is high for exactly the one cycle after a failing check, and low after every other cycle.
- R10: A failing check captures base_addr, the lower field, the stored upper field and the side into the record, with viol_side 1 for op codes 6 and 7. The record is captured when viol_valid is low or viol_ack is high in that same cycle. Otherwise the record held from earlier stays unchanged.
- R11: viol_ack with no failing check in the same cycle clears viol_valid on the next cycle.
- R12: With op_valid low, no register changes, no pulse is raised and mem_rvalid stays low, whatever op_code carries.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| op_valid | input | 1 | Operation strobe |
| op_code | input | 3 | 0 none, 1 make, 2 copy, 3 load, 4 spill, 5 lower check, 6 direct upper check, 7 inverting upper check |
| dst_sel | input | 2 | Destination register |
| src_sel | input | 2 | Source or checked register |
| base_addr | input | 64 | Base for make, address for checks |
| offset | input | 64 | Offset for make |
| mem_wdata | input | 128 | Image written by load |
| mem_rdata | output | 128 | Image read by spill |
| mem_rvalid | output | 1 | mem_rdata valid |
| viol_ack | input | 1 | Clears the held record |
| viol_pulse | output | 1 | One-cycle violation strobe |
| viol_valid | output | 1 | A record is held |
| viol_addr | output | 64 | Address that failed |
| viol_lo | output | 64 | Lower field used |
| viol_up | output | 64 | Stored upper field used |
| viol_side | output | 1 | 0 lower side, 1 upper side |

## Verification
The hardest situation to reach is a new violation arriving while an earlier record is still held. It has to be tested both with and without an acknowledge in the same cycle, because one case must keep the old record and the other must replace it. The stimulus reaches it with back-to-back failing checks that have distinct addresses and sides, and then repeats the pair with viol_ack raised on the second check. A long stretch of mixed operations then follows. Its addresses and offsets are drawn from a narrow range, so that checks often fall on a bound, one past a bound, or on a register still holding the all-zero image.

// File: rtl/bnd_pkg.sv
package bnd_pkg;
  localparam int BND_AW = 64;
  localparam int BND_BW = 2 * BND_AW;

  typedef enum logic [2:0] {
    OP_NOP   = 3'd0,
    OP_MAKE  = 3'd1,
    OP_COPY  = 3'd2,
    OP_LOAD  = 3'd3,
    OP_STORE = 3'd4,
    OP_CHKL  = 3'd5,
    OP_CHKU  = 3'd6,
    OP_CHKUC = 3'd7
  } bnd_op_e;

  // Image built by a make operation: upper end kept inverted.
  function automatic logic [BND_BW-1:0] bnd_make(input logic [BND_AW-1:0] base,
                                                 input logic [BND_AW-1:0] off);
    logic [BND_AW-1:0] last;
    last = base + off;
    return {~last, base};
  endfunction

  // Upper bound actually compared, given the stored field and the check form.
  function automatic logic [BND_AW-1:0] bnd_up_eff(input logic [BND_AW-1:0] stored,
                                                   input logic inverted);
    return inverted ? ~stored : stored;
  endfunction

  function automatic logic bnd_is_init(input logic [BND_BW-1:0] img);
    return img == '0;
  endfunction
endpackage

// File: rtl/bnd_regfile.sv
module bnd_regfile #(
  parameter int NREG = 4,
  parameter int AW   = bnd_pkg::BND_AW,
  localparam int IW  = $clog2(NREG),
  localparam int BW  = 2 * AW
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          wr_en,
  input  logic [IW-1:0] wr_idx,
  input  logic [BW-1:0] wr_data,
  input  logic [IW-1:0] rd_idx,
  output logic [BW-1:0] rd_data
);
  logic [BW-1:0] bank [NREG];

  for (genvar g = 0; g < NREG; g++) begin : g_slot
    logic [BW-1:0] q;
    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)
        q <= '0;
      else if (wr_en && wr_idx == IW'(g))
        q <= wr_data;
    end
    assign bank[g] = q;
  end

  assign rd_data = bank[rd_idx];
endmodule

// File: rtl/bnd_cmp.sv
module bnd_cmp #(
  parameter int AW  = bnd_pkg::BND_AW,
  localparam int BW = 2 * AW
) (
  input  logic          en,
  input  logic [2:0]    kind,
  input  logic [AW-1:0] addr,
  input  logic [BW-1:0] img,
  output logic          fail,
  output logic          side_up,
  output logic          img_init
);
  import bnd_pkg::*;

  logic [AW-1:0] lo_f, up_f, up_cmp;
  logic          lo_cross, up_cross;
  bnd_op_e       k;

  always_comb begin
    k        = bnd_op_e'(kind);
    lo_f     = img[AW-1:0];
    up_f     = img[BW-1:AW];
    img_init = bnd_is_init(img);
    up_cmp   = bnd_up_eff(up_f, k == OP_CHKUC);
    lo_cross = addr < lo_f;
    up_cross = addr > up_cmp;
    side_up  = (k == OP_CHKU) || (k == OP_CHKUC);
    fail     = 1'b0;
    if (en && !img_init) begin
      unique case (k)
        OP_CHKL:          fail = lo_cross;
        OP_CHKU, OP_CHKUC: fail = up_cross;
        default:          fail = 1'b0;
      endcase
    end
  end
endmodule

// File: rtl/bnd_viol_rec.sv
module bnd_viol_rec #(
  parameter int AW = bnd_pkg::BND_AW
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          fail,
  input  logic          side_in,
  input  logic [AW-1:0] addr_in,
  input  logic [AW-1:0] lo_in,
  input  logic [AW-1:0] up_in,
  input  logic          ack,
  output logic          pulse,
  output logic          valid,
  output logic [AW-1:0] r_addr,
  output logic [AW-1:0] r_lo,
  output logic [AW-1:0] r_up,
  output logic          r_side
);
  logic take;
  assign take = fail && (!valid || ack);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      pulse  <= 1'b0;
      valid  <= 1'b0;
      r_addr <= '0;
      r_lo   <= '0;
      r_up   <= '0;
      r_side <= 1'b0;
    end else begin
      pulse <= fail;
      if (take) begin
        valid  <= 1'b1;
        r_addr <= addr_in;
        r_lo   <= lo_in;
        r_up   <= up_in;
        r_side <= side_in;
      end else if (ack) begin
        valid <= 1'b0;
      end
    end
  end
endmodule

// File: rtl/bnd_check_unit.sv
module bnd_check_unit #(
  parameter int NREG = 4,
  parameter int AW   = bnd_pkg::BND_AW,
  localparam int IW  = $clog2(NREG),
  localparam int BW  = 2 * AW
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          op_valid,
  input  logic [2:0]    op_code,
  input  logic [IW-1:0] dst_sel,
  input  logic [IW-1:0] src_sel,
  input  logic [AW-1:0] base_addr,
  input  logic [AW-1:0] offset,
  input  logic [BW-1:0] mem_wdata,
  output logic [BW-1:0] mem_rdata,
  output logic          mem_rvalid,
  input  logic          viol_ack,
  output logic          viol_pulse,
  output logic          viol_valid,
  output logic [AW-1:0] viol_addr,
  output logic [AW-1:0] viol_lo,
  output logic [AW-1:0] viol_up,
  output logic          viol_side
);
  import bnd_pkg::*;

  bnd_op_e       op;
  logic          wr_en, chk_active, chk_fail, chk_side, sel_init, spill_now;
  logic [BW-1:0] wr_data, src_img;

  always_comb begin
    op         = bnd_op_e'(op_code);
    wr_en      = 1'b0;
    wr_data    = '0;
    chk_active = 1'b0;
    spill_now  = 1'b0;
    if (op_valid) begin
      unique case (op)
        OP_MAKE: begin wr_en = 1'b1; wr_data = bnd_make(base_addr, offset); end
        OP_COPY: begin wr_en = 1'b1; wr_data = src_img; end
        OP_LOAD: begin wr_en = 1'b1; wr_data = mem_wdata; end
        OP_STORE: spill_now = 1'b1;
        OP_CHKL, OP_CHKU, OP_CHKUC: chk_active = 1'b1;
        default: ;
      endcase
    end
  end

  bnd_regfile #(.NREG(NREG), .AW(AW)) u_rf (
    .clk(clk), .rst_n(rst_n),
    .wr_en(wr_en), .wr_idx(dst_sel), .wr_data(wr_data),
    .rd_idx(src_sel), .rd_data(src_img)
  );

  bnd_cmp #(.AW(AW)) u_cmp (
    .en(chk_active), .kind(op_code), .addr(base_addr), .img(src_img),
    .fail(chk_fail), .side_up(chk_side), .img_init(sel_init)
  );

  bnd_viol_rec #(.AW(AW)) u_rec (
    .clk(clk), .rst_n(rst_n),
    .fail(chk_fail), .side_in(chk_side), .addr_in(base_addr),
    .lo_in(src_img[AW-1:0]), .up_in(src_img[BW-1:AW]), .ack(viol_ack),
    .pulse(viol_pulse), .valid(viol_valid), .r_addr(viol_addr),
    .r_lo(viol_lo), .r_up(viol_up), .r_side(viol_side)
  );

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      mem_rvalid <= 1'b0;
      mem_rdata  <= '0;
    end else begin
      mem_rvalid <= spill_now;
      if (spill_now) mem_rdata <= src_img;
    end
  end
endmodule

// File: rtl/bnd_check_unit_sva.sv
module bnd_check_unit_sva #(
  parameter int AW = 64
) (
  input logic          clk,
  input logic          rst_n,
  input logic          op_valid,
  input logic [2:0]    op_code,
  input logic          viol_ack,
  input logic          viol_pulse,
  input logic          viol_valid,
  input logic [AW-1:0] viol_addr,
  input logic [AW-1:0] viol_lo,
  input logic [AW-1:0] viol_up,
  input logic          mem_rvalid,
  input logic          chk_fail,
  input logic          chk_active,
  input logic          sel_init
);
  assert_pulse_has_record_R9: assert property (@(posedge clk) disable iff (!rst_n)
    viol_pulse |-> viol_valid);

  assert_pulse_follows_fail_R9: assert property (@(posedge clk) disable iff (!rst_n)
    chk_fail |=> viol_pulse);

  assert_record_held_R10: assert property (@(posedge clk) disable iff (!rst_n)
    (viol_valid && !viol_ack) |=> (viol_valid && $stable(viol_addr) && $stable(viol_lo) && $stable(viol_up)));

  assert_ack_clears_R11: assert property (@(posedge clk) disable iff (!rst_n)
    (viol_ack && !chk_fail) |=> !viol_valid);

  assert_spill_strobe_R4: assert property (@(posedge clk) disable iff (!rst_n)
    (op_valid && op_code == 3'd4) |=> mem_rvalid);

  assert_idle_quiet_R12: assert property (@(posedge clk) disable iff (!rst_n)
    !op_valid |=> (!viol_pulse && !mem_rvalid));

  assert_init_passes_R8: assert property (@(posedge clk) disable iff (!rst_n)
    (chk_active && sel_init) |-> !chk_fail);
endmodule

bind bnd_check_unit bnd_check_unit_sva #(.AW(AW)) u_sva (
  .clk(clk), .rst_n(rst_n), .op_valid(op_valid), .op_code(op_code),
  .viol_ack(viol_ack), .viol_pulse(viol_pulse), .viol_valid(viol_valid),
  .viol_addr(viol_addr), .viol_lo(viol_lo), .viol_up(viol_up),
  .mem_rvalid(mem_rvalid), .chk_fail(chk_fail), .chk_active(chk_active),
  .sel_init(sel_init)
);

// File: tb/sim_bnd_check_unit.sv
`timescale 1ns/1ps
module sim_bnd_check_unit;
  localparam logic [63:0] ONES = 64'hFFFF_FFFF_FFFF_FFFF;

  logic clk = 1'b0;
  always #4 clk = ~clk;

  logic rst_n, op_valid, viol_ack;
  logic [2:0] op_code;
  logic [1:0] dst_sel, src_sel;
  logic [63:0] base_addr, offset;
  logic [127:0] mem_wdata, mem_rdata;
  logic mem_rvalid, viol_pulse, viol_valid, viol_side;
  logic [63:0] viol_addr, viol_lo, viol_up;

  bnd_check_unit u0 (
    .clk(clk), .rst_n(rst_n), .op_valid(op_valid), .op_code(op_code),
    .dst_sel(dst_sel), .src_sel(src_sel), .base_addr(base_addr), .offset(offset),
    .mem_wdata(mem_wdata), .mem_rdata(mem_rdata), .mem_rvalid(mem_rvalid),
    .viol_ack(viol_ack), .viol_pulse(viol_pulse), .viol_valid(viol_valid),
    .viol_addr(viol_addr), .viol_lo(viol_lo), .viol_up(viol_up), .viol_side(viol_side)
  );

  // reference model state
  logic [127:0] m_reg [4];
  logic [127:0] m_rd;
  logic m_rv, m_pulse, m_valid, m_side;
  logic [63:0] m_addr, m_lo, m_up;

  integer total = 0;
  integer bad = 0;
  bit done = 0;

  task automatic chk(input string tag, input logic [127:0] act, input logic [127:0] exp);
    total++;
    if (act !== exp) begin
      bad++;
      $display("FAIL %s actual=%h expected=%h", tag, act, exp);
    end
  endtask

  task automatic compare_all(input string tag);
    chk({tag, " R4 mem_rvalid"}, {127'd0, mem_rvalid}, {127'd0, m_rv});
    if (m_rv) chk({tag, " R4 mem_rdata"}, mem_rdata, m_rd);
    chk({tag, " R9 viol_pulse"}, {127'd0, viol_pulse}, {127'd0, m_pulse});
    chk({tag, " R11 viol_valid"}, {127'd0, viol_valid}, {127'd0, m_valid});
    if (m_valid) begin
      chk({tag, " R10 addr"}, {64'd0, viol_addr}, {64'd0, m_addr});
      chk({tag, " R10 bounds"}, {viol_up, viol_lo}, {m_up, m_lo});
      chk({tag, " R10 side"}, {127'd0, viol_side}, {127'd0, m_side});
    end
  endtask

  // model: which checks fail, written from the requirement text
  function automatic bit model_fail(input logic [2:0] op, input logic [127:0] img,
                                    input logic [63:0] a);
    logic [63:0] lo, up;
    lo = img[63:0];
    up = img[127:64];
    if (img == 128'd0) return 0;            // R8
    case (op)
      3'd5: return a < lo;                  // R5
      3'd6: return a > up;                  // R6
      3'd7: return a > (ONES - up);         // R7
      default: return 0;
    endcase
  endfunction

  task automatic step(input bit v, input logic [2:0] op, input logic [1:0] d,
                      input logic [1:0] s, input logic [63:0] a, input logic [63:0] o,
                      input logic [127:0] w, input bit ack, input string tag);
    bit f;
    op_valid = v; op_code = op; dst_sel = d; src_sel = s;
    base_addr = a; offset = o; mem_wdata = w; viol_ack = ack;
    f = v && model_fail(op, m_reg[s], a);
    m_pulse = f;
    if (f && (!m_valid || ack)) begin
      m_valid = 1; m_addr = a; m_lo = m_reg[s][63:0]; m_up = m_reg[s][127:64];
      m_side = (op != 3'd5);
    end else if (ack && !f) m_valid = 0;
    m_rv = v && op == 3'd4;
    if (m_rv) m_rd = m_reg[s];
    if (v) begin
      if (op == 3'd1) m_reg[d] = {ONES - (a + o), a};   // R3
      else if (op == 3'd2) m_reg[d] = m_reg[s];
      else if (op == 3'd3) m_reg[d] = w;
    end
    @(negedge clk);
    compare_all(tag);
  endtask

  initial begin
    #(8 * 150000);
    $display("FAIL watchdog R9 actual=running expected=finished");
    total++; bad++;
    if (!done) begin
      $display("  test done: total=%0d bad=%0d", total, bad);
      done = 1;
    end
    $finish;
  end

  initial begin
    logic [31:0] lf;
    rst_n = 0; op_valid = 0; op_code = 0; dst_sel = 0; src_sel = 0;
    base_addr = 0; offset = 0; mem_wdata = 0; viol_ack = 0;
    for (int i = 0; i < 4; i++) m_reg[i] = 128'd0;
    m_rd = 0; m_rv = 0; m_pulse = 0; m_valid = 0; m_side = 0;
    m_addr = 0; m_lo = 0; m_up = 0;
    repeat (3) @(negedge clk);
    rst_n = 1;
    @(negedge clk);
    compare_all("reset R1");
    for (int i = 0; i < 4; i++) step(1, 3'd4, 0, 2'(i), 0, 0, 0, 0, "R1 spill after reset");

    // R3 / R2: make bounds for ten 8-byte items
    step(1, 3'd1, 1, 0, 64'h1000, 64'd79, 0, 0, "R3 make");
    step(1, 3'd4, 0, 1, 0, 0, 0, 0, "R3 spill");
    chk("R2 lower field", {64'd0, mem_rdata[63:0]}, {64'd0, 64'h1000});
    chk("R2 upper field", {64'd0, mem_rdata[127:64]}, {64'd0, ~64'h104F});

    // R5 lower check edges
    step(1, 3'd5, 0, 1, 64'h1000, 0, 0, 0, "R5 equal lower");
    step(1, 3'd5, 0, 1, 64'h0FFF, 0, 0, 0, "R5 below lower");
    step(1, 3'd0, 0, 0, 0, 0, 0, 1, "R11 ack");
    // R7 inverting upper check edges
    step(1, 3'd7, 0, 1, 64'h104F, 0, 0, 0, "R7 equal upper");
    step(1, 3'd7, 0, 1, 64'h1050, 0, 0, 0, "R7 above upper");
    step(1, 3'd6, 0, 1, 64'h1050, 0, 0, 1, "R6 direct on inverted form");
    // R6 direct form loaded from memory port
    step(1, 3'd3, 2, 0, 0, 0, {64'h20, 64'h10}, 0, "R4 load");
    step(1, 3'd6, 0, 2, 64'h20, 0, 0, 0, "R6 equal upper");
    step(1, 3'd6, 0, 2, 64'h21, 0, 0, 0, "R6 above upper");
    step(1, 3'd0, 0, 0, 0, 0, 0, 1, "R11 ack 2");

    // R8 always-true image in r0
    step(1, 3'd5, 0, 0, 64'd0, 0, 0, 0, "R8 lower");
    step(1, 3'd6, 0, 0, ONES, 0, 0, 0, "R8 direct upper");
    step(1, 3'd7, 0, 0, ONES, 0, 0, 0, "R8 inverting upper");

    // R10 second violation while held, then with ack
    step(1, 3'd5, 0, 2, 64'h5, 0, 0, 0, "R10 first");
    step(1, 3'd6, 0, 2, 64'h99, 0, 0, 0, "R10 no overwrite");
    chk("R10 kept side", {127'd0, viol_side}, 128'd0);
    step(1, 3'd6, 0, 2, 64'h77, 0, 0, 1, "R10 ack replaces");
    chk("R10 new addr", {64'd0, viol_addr}, {64'd0, 64'h77});
    step(1, 3'd0, 0, 0, 0, 0, 0, 1, "R11 clear");

    // R12 ignored operations
    step(0, 3'd1, 3, 0, 64'h4444, 64'h4, 0, 0, "R12 make ignored");
    step(0, 3'd5, 0, 2, 64'h0, 0, 0, 0, "R12 check ignored");
    step(0, 3'd4, 0, 3, 0, 0, 0, 0, "R12 spill ignored");
    step(1, 3'd4, 0, 3, 0, 0, 0, 0, "R12 r3 untouched");
    chk("R12 r3 still zero", mem_rdata, 128'd0);

    // R4 copy
    step(1, 3'd2, 3, 1, 0, 0, 0, 0, "R4 copy");
    step(1, 3'd4, 0, 3, 0, 0, 0, 0, "R4 spill copy");

    // mixed stream on a narrow value range
    lf = 32'hACE1_1234;
    for (int n = 0; n < 3000; n++) begin
      lf = {lf[30:0], lf[31] ^ lf[21] ^ lf[1] ^ lf[0]};
      step(lf[3], lf[6:4], lf[8:7], lf[10:9], {56'd0, lf[18:11]}, {58'd0, lf[24:19]},
           {56'd0, lf[31:24], 56'd0, lf[23:16]}, lf[25], "R9 mixed");
    end

    if (!done) begin
      $display("  test done: total=%0d bad=%0d", total, bad);
      done = 1;
    end
    $finish;
  end
endmodule